// File: doc/BRIEF.md
# Multi-strobe serial DAC input interface

This block is the digital front end of a serial-input multiplying DAC. One serial data pin feeds a shift register. Four strobe pins clock that register. Three of the strobes act on a rising edge and one acts on a falling edge. A second register, the DAC register, holds the code that drives the converter. It is loaded in parallel from the shift register only while two active-low load pins are both low. Because the two registers are separate, several converters can be filled one at a time and then updated together. An asynchronous active-low clear forces the DAC register to zero and leaves the shift register unchanged.

All pins are external and asynchronous. The block works in a single system clock domain. The four strobes are first merged into one enable level, and the two load pins into one request. These two signals and the serial data then pass through the same two-flop synchronizer. A shift happens once for each 0-to-1 transition of the synchronized enable. A strobe held in its active state keeps the enable high, so edges on the other strobes produce no shifts.

Top module: `sdac_front`

## Requirements
- R1: After `rst_n` is released, `code_out` reads zero.
- R2: A rising edge on `strobe_r0`, `strobe_r1` or `strobe_r2` shifts exactly one bit into the shift register, provided the other strobes are idle (low for the rising ones, high for `strobe_f`). The bit shifted is the value `ser_in` had when the strobe edge occurred.
- R3: A falling edge on `strobe_f`, with the other strobes idle, shifts exactly one bit taken from `ser_in`.
- R4: Data enters MSB first. Each shift moves the register one place toward bit WIDTH-1 and puts the new bit in bit 0. After WIDTH shifts, the first bit received sits in bit WIDTH-1. Any further shift discards the oldest bit.
- R5: A strobe held in its active state (high for the rising strobes, low for `strobe_f`) blocks all further shifts, whatever edges occur on the other strobes.
- R6: The DAC register is loaded only while `load0_n` and `load1_n` are both low. If only one of them is low, `code_out` does not change.
- R7: While both load pins stay low, the DAC register copies the shift register on every clock. As a result, `code_out` follows shifts made during the load window.
- R8: Driving `clear_n` low zeroes `code_out` at once, without waiting for a clock edge. The shift register keeps its contents, and a later load shows them.
- R9: `clear_n` takes priority over the load pins. While `clear_n` is low, `code_out` stays zero even if both load pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for all state |
| ser_in | input | 1 | Serial data input |
| strobe_r0 | input | 1 | Shift strobe, active on rising edge |
| strobe_r1 | input | 1 | Shift strobe, active on rising edge |
| strobe_r2 | input | 1 | Shift strobe, active on rising edge |
| strobe_f | input | 1 | Shift strobe, active on falling edge |
| load0_n | input | 1 | Active-low load enable, first of the pair |
| load1_n | input | 1 | Active-low load enable, second of the pair |
| clear_n | input | 1 | Active-low asynchronous clear of the DAC register |
| code_out | output | WIDTH | DAC register contents (converter code) |

## Verification
The bench builds the block with WIDTH = 4 and the default two synchronizer stages. With that width, every possible code can be shifted in and loaded. The sweep rotates across all four strobes, and each expected word is computed by arithmetic. The narrow register also makes some corner cases cheap to reach: shifts past WIDTH that drop bits, a held strobe blocking others of either polarity, single-pin loads, loads during a shift, and clear overlapping a load.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Control bundle carried through the pin synchronizer
    typedef struct packed {
        logic en;    // merged strobe level, high while any strobe is active
        logic data;  // serial data
        logic load;  // both load pins low
    } sdac_ctl_t;

    localparam int CTL_W = $bits(sdac_ctl_t);

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             data_s,
    output logic [WIDTH-1:0] shreg_o
);

    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic             en_prev;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d         = state_q;
        state_d.en_prev = en_s;
        if (en_s && !state_q.en_prev) begin
            state_d.sh = {state_q.sh[WIDTH-2:0], data_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign shreg_o = state_q.sh;

    // R5
    held_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && $past(en_s)) |=> $stable(shreg_o));

    // R4
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && !state_q.en_prev) |=>
            (shreg_o == {$past(shreg_o[WIDTH-2:0]), $past(data_s)}));

    // R2
    idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s) |=> $stable(shreg_o));

endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_n,
    input  logic             load_s,
    input  logic [WIDTH-1:0] par_i,
    output logic [WIDTH-1:0] dac_o
);

    typedef struct packed {
        logic [WIDTH-1:0] dac;
    } hold_state_t;

    hold_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_s) state_d.dac = par_i;
    end

    always_ff @(posedge clk or negedge rst_n or negedge clear_n) begin
        if (!rst_n || !clear_n) state_q <= '0;
        else                    state_q <= state_d;
    end

    assign dac_o = state_q.dac;

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n) |-> (dac_o == '0));

    // R7
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        load_s |=> (dac_o == $past(par_i)));

    // R6
    no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        (!load_s) |=> $stable(dac_o));

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             strobe_r0,
    input  logic             strobe_r1,
    input  logic             strobe_r2,
    input  logic             strobe_f,
    input  logic             load0_n,
    input  logic             load1_n,
    input  logic             clear_n,
    output logic [WIDTH-1:0] code_out
);

    sdac_ctl_t        ctl_raw, ctl_s;
    logic [CTL_W-1:0] ctl_sync_bits;
    logic [WIDTH-1:0] shreg;

    always_comb begin
        ctl_raw.en   = strobe_r0 | strobe_r1 | strobe_r2 | ~strobe_f;
        ctl_raw.data = ser_in;
        ctl_raw.load = ~load0_n & ~load1_n;
    end

    sdac_sync #(
        .N      (CTL_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_raw),
        .sync_o  (ctl_sync_bits)
    );

    assign ctl_s = sdac_ctl_t'(ctl_sync_bits);

    sdac_shift #(
        .WIDTH (WIDTH)
    ) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (ctl_s.en),
        .data_s  (ctl_s.data),
        .shreg_o (shreg)
    );

    sdac_hold #(
        .WIDTH (WIDTH)
    ) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_n (clear_n),
        .load_s  (ctl_s.load),
        .par_i   (shreg),
        .dac_o   (code_out)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        (!rst_n) |-> (code_out == '0));

endmodule

// File: tb/test_sdac_front.sv
module test_sdac_front;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_in = 1'b0;
    logic         strobe_r0 = 1'b0;
    logic         strobe_r1 = 1'b0;
    logic         strobe_r2 = 1'b0;
    logic         strobe_f = 1'b1;
    logic         load0_n = 1'b1;
    logic         load1_n = 1'b1;
    logic         clear_n = 1'b1;
    logic [W-1:0] code_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdac_front #(.WIDTH(W), .SYNC_STAGES(2)) i_sdac_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .strobe_r0 (strobe_r0),
        .strobe_r1 (strobe_r1),
        .strobe_r2 (strobe_r2),
        .strobe_f  (strobe_f),
        .load0_n   (load0_n),
        .load1_n   (load1_n),
        .clear_n   (clear_n),
        .code_out  (code_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: code_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_strobe(input int idx, input bit active);
        case (idx)
            0: strobe_r0 = active;
            1: strobe_r1 = active;
            2: strobe_r2 = active;
            default: strobe_f = ~active;
        endcase
    endtask

    task automatic pulse_bit(input int idx, input bit b);
        ser_in = b;
        wait_clk(1);
        set_strobe(idx, 1'b1);
        wait_clk(3);
        set_strobe(idx, 1'b0);
        wait_clk(3);
    endtask

    task automatic send(input int idx, input int nbits, input int value);
        for (int i = nbits - 1; i >= 0; i--) pulse_bit(idx, value[i]);
    endtask

    task automatic do_load();
        load0_n = 1'b0;
        load1_n = 1'b0;
        wait_clk(4);
        load0_n = 1'b1;
        load1_n = 1'b1;
        wait_clk(4);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 reset", code_out, '0);

        // R2 / R3 / R4: every code through a rotating strobe
        for (int v = 0; v < (1 << W); v++) begin
            send(v % 4, W, v);
            do_load();
            check((v % 4 == 3) ? "R3 falling strobe word" : "R2 rising strobe word",
                  code_out, W'(v));
        end

        // R4: extra shifts drop the oldest bits
        send(1, 6, 6'b101101);
        do_load();
        check("R4 overflow keeps newest bits", code_out, W'(6'b101101));

        // R5: held rising strobe blocks the others
        send(2, W, 4'hA);
        ser_in = 1'b0;
        wait_clk(1);
        strobe_r0 = 1'b1;
        wait_clk(4);
        pulse_bit(1, 1'b1);
        pulse_bit(3, 1'b1);
        pulse_bit(2, 1'b1);
        strobe_r0 = 1'b0;
        wait_clk(4);
        do_load();
        check("R5 held rising strobe blocks", code_out, W'(4'hA << 1));

        // R5: held falling strobe blocks the others
        send(0, W, 4'h9);
        ser_in = 1'b1;
        wait_clk(1);
        strobe_f = 1'b0;
        wait_clk(4);
        pulse_bit(0, 1'b0);
        pulse_bit(2, 1'b0);
        strobe_f = 1'b1;
        wait_clk(4);
        do_load();
        check("R5 held falling strobe blocks", code_out, W'((4'h9 << 1) | 1));

        // R6: single load pin has no effect
        send(0, W, 4'h5);
        do_load();
        send(3, W, 4'h3);
        load0_n = 1'b0;
        wait_clk(6);
        load0_n = 1'b1;
        wait_clk(4);
        check("R6 load0_n alone", code_out, 4'h5);
        load1_n = 1'b0;
        wait_clk(6);
        load1_n = 1'b1;
        wait_clk(4);
        check("R6 load1_n alone", code_out, 4'h5);
        do_load();
        check("R6 both low loads", code_out, 4'h3);

        // R7: DAC register follows shifts during a load window
        load0_n = 1'b0;
        load1_n = 1'b0;
        wait_clk(4);
        pulse_bit(2, 1'b1);
        check("R7 follows shift in load window", code_out, 4'h7);
        load0_n = 1'b1;
        load1_n = 1'b1;
        wait_clk(4);

        // R8: asynchronous clear, shift register kept
        #1 clear_n = 1'b0;
        #1 check("R8 clear is immediate", code_out, '0);
        wait_clk(1);
        clear_n = 1'b1;
        wait_clk(4);
        check("R8 stays zero after clear", code_out, '0);
        do_load();
        check("R8 shift register kept", code_out, 4'h7);

        // R9: clear dominates load
        clear_n = 1'b0;
        load0_n = 1'b0;
        load1_n = 1'b0;
        wait_clk(5);
        check("R9 clear over load", code_out, '0);
        clear_n = 1'b1;
        wait_clk(4);
        check("R9 load resumes after clear", code_out, 4'h7);
        load0_n = 1'b1;
        load1_n = 1'b1;
        wait_clk(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule